// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources for a small CPU and decides which one, if any, should interrupt the core. Each source owns a sticky pending flag, an enable bit and a 3-bit priority field. All of these sit behind a simple single-cycle register read/write bus. Every cycle an arbiter looks at the sources that are both flagged and enabled and picks the one with the highest programmed priority. When priorities are equal, the lower source index wins. The arbiter's choice is latched as a 7-bit vector number and a 4-bit level.

The latched level is compared with the current CPU priority. That priority is formed from a 3-bit software-writable field and a read-only top bit, which reflects the core's trap state. An interrupt request goes to the CPU only when the winning level is strictly above that priority. When the CPU acknowledges, the controller raises the CPU priority to the winning level. If nesting has been turned off, it raises the priority to 7 instead, so that no user source can preempt the running handler. Software clears flags and lowers the priority again when the handler returns.

Top module: `ivc_top`

## Requirements
- R1: A high cycle on `src_i[k]` sets flag k at the next clock edge. The flag stays set until software writes a 1 to bit k%16 of the flag register at address 8+k/16 (write-one-to-clear). Zeros in the written data leave flags untouched, and reading that address returns the flags.
- R2: When a source is high in the same cycle as a software write that clears its flag, the flag ends up set.
- R3: A flagged source whose enable bit (bit k%16 at address 12+k/16, read/write) is 0 never wins arbitration and never raises `irq_o`.
- R4: The priority of source k is written and read at address 16+k/4, bits 4*(k%4)+2 down to 4*(k%4). Bit 4*(k%4)+3 always reads 0. A priority of 0 keeps the source out of arbitration.
- R5: Among flagged and enabled sources with nonzero priority, the one with the highest priority wins. The controller latches vector 8+k and level {0, priority} one clock edge after the flag register shows the request. With no candidate, the vector and the level are both 0.
- R6: Among candidates with equal priority, the lowest source index wins.
- R7: `irq_o` is high exactly when the latched level is strictly greater than `cpu_lvl_o`.
- R8: Address 1 holds the CPU priority. A write stores bits 2:0 only. A read and `cpu_lvl_o` return {`trap_i`, stored bits}, so software cannot write the top bit. While `trap_i` is high, no user source raises `irq_o`. The stored bits change only through a write to address 1 or an acknowledge.
- R9: When `ack_i` is high while `irq_o` is high, the stored CPU priority becomes the low 3 bits of the latched level. If the nesting-off bit (address 0, bit 0, read/write) is set, the stored priority becomes 7 instead. When `irq_o` is low, `ack_i` has no effect.
- R10: Address 2 reads the latched result, with the vector in bits 6:0 and the level in bits 11:8. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Peripheral request lines, one per source |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| trap_i | input | 1 | Core trap state, read-only top bit of CPU priority |
| ack_i | input | 1 | CPU interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 7 | Latched winning vector number |
| lvl_o | output | 4 | Latched winning level |
| cpu_lvl_o | output | 4 | Current CPU priority |

## Verification
The hardest case to reach from the ports is a source pulse and a software clear of the same flag landing on the same clock edge. The stimulus raises the source and issues the clearing write in one and the same low clock phase, then reads the flag back. Ties between sources and the interplay of acknowledge, nesting-off and the trap bit are reached by programming priorities so that the expected winner differs from the one a plain index scan or a plain priority scan would pick.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'd0;
  localparam logic [ADDR_W-1:0] A_CPU  = 6'd1;
  localparam logic [ADDR_W-1:0] A_RES  = 6'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 6'd8;
  localparam logic [ADDR_W-1:0] A_EN   = 6'd12;
  localparam logic [ADDR_W-1:0] A_PRIO = 6'd16;

  typedef struct packed {
    logic [6:0] vec;
    logic [3:0] lvl;
  } win_t;
endpackage

// File: rtl/ivc_arb.sv
module ivc_arb
  import ivc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int VEC_BASE = 8
) (
  input  logic [NUM_SRC-1:0]   flag_i,
  input  logic [NUM_SRC-1:0]   en_i,
  input  logic [3*NUM_SRC-1:0] prio_i,
  output win_t                 win_o
);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [2:0]       best_lvl;
  logic [SRC_W-1:0] best_idx;

  // descending scan with >= leaves the lowest index on ties
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (flag_i[i] && en_i[i] && (prio_i[3*i +: 3] != 3'd0) &&
          (prio_i[3*i +: 3] >= best_lvl)) begin
        best_lvl = prio_i[3*i +: 3];
        best_idx = SRC_W'(i);
      end
    end
  end

  always_comb begin
    win_o.lvl = {1'b0, best_lvl};
    win_o.vec = (best_lvl == 3'd0) ? 7'd0 : 7'(VEC_BASE + int'(best_idx));
  end
endmodule

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  win_t                 res_i,
  input  logic                 trap_i,
  input  logic                 ack_fire_i,
  input  logic [2:0]           ack_lvl_i,
  output logic [NUM_SRC-1:0]   flag_o,
  output logic [NUM_SRC-1:0]   en_o,
  output logic [3*NUM_SRC-1:0] prio_o,
  output logic                 nest_off_o,
  output logic [2:0]           ipl_o
);
  localparam int NREG  = NUM_SRC / 16;
  localparam int NPRIO = NUM_SRC / 4;

  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] en_q;
  logic [2:0]         prio_q [NUM_SRC];
  logic               nest_off_q;
  logic [2:0]         ipl_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(int'(A_FLAG) + k / 16);
    localparam logic [ADDR_W-1:0] PA = ADDR_W'(int'(A_PRIO) + k / 4);
    logic clr;
    assign clr = we_i && (addr_i == FA) && wdata_i[k % 16];

    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[k] <= 1'b0;
      else         flag_q[k] <= src_i[k] | (flag_q[k] & ~clr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    prio_q[k] <= 3'd0;
      else if (we_i && addr_i == PA)  prio_q[k] <= wdata_i[4*(k%4) +: 3];
    end

    assign prio_o[3*k +: 3] = prio_q[k];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_en
    localparam logic [ADDR_W-1:0] EA = ADDR_W'(int'(A_EN) + r);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   en_q[16*r +: 16] <= '0;
      else if (we_i && addr_i == EA) en_q[16*r +: 16] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       nest_off_q <= 1'b0;
    else if (we_i && addr_i == A_CTRL) nest_off_q <= wdata_i[0];
  end

  // acknowledge outranks a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ipl_q <= 3'd0;
    else if (ack_fire_i)              ipl_q <= nest_off_q ? 3'd7 : ack_lvl_i;
    else if (we_i && addr_i == A_CPU) ipl_q <= wdata_i[2:0];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) rdata_o[0] = nest_off_q;
    if (addr_i == A_CPU)  rdata_o[3:0] = {trap_i, ipl_q};
    if (addr_i == A_RES)  rdata_o = {4'd0, res_i.lvl, 1'b0, res_i.vec};
    for (int r = 0; r < NREG; r++) begin
      if (addr_i == ADDR_W'(int'(A_FLAG) + r)) rdata_o = flag_q[16*r +: 16];
      if (addr_i == ADDR_W'(int'(A_EN) + r))   rdata_o = en_q[16*r +: 16];
    end
    for (int p = 0; p < NPRIO; p++) begin
      if (addr_i == ADDR_W'(int'(A_PRIO) + p)) begin
        for (int n = 0; n < 4; n++) rdata_o[4*n +: 3] = prio_q[4*p + n];
      end
    end
  end

  assign flag_o     = flag_q;
  assign en_o       = en_q;
  assign nest_off_o = nest_off_q;
  assign ipl_o      = ipl_q;
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int VEC_BASE = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                we_i,
  input  logic [5:0]          addr_i,
  input  logic [15:0]         wdata_i,
  output logic [15:0]         rdata_o,
  input  logic                trap_i,
  input  logic                ack_i,
  output logic                irq_o,
  output logic [6:0]          vec_o,
  output logic [3:0]          lvl_o,
  output logic [3:0]          cpu_lvl_o
);
  logic [NUM_SRC-1:0]   flag_w;
  logic [NUM_SRC-1:0]   en_w;
  logic [3*NUM_SRC-1:0] prio_w;
  logic                 nest_off_w;
  logic [2:0]           ipl_w;
  logic                 ack_fire;
  win_t                 win_d, res_q;

  ivc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .res_i      (res_q),
    .trap_i     (trap_i),
    .ack_fire_i (ack_fire),
    .ack_lvl_i  (res_q.lvl[2:0]),
    .flag_o     (flag_w),
    .en_o       (en_w),
    .prio_o     (prio_w),
    .nest_off_o (nest_off_w),
    .ipl_o      (ipl_w)
  );

  ivc_arb #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_arb (
    .flag_i (flag_w),
    .en_i   (en_w),
    .prio_i (prio_w),
    .win_o  (win_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= win_d;
  end

  assign cpu_lvl_o = {trap_i, ipl_w};
  assign irq_o     = res_q.lvl > cpu_lvl_o;
  assign ack_fire  = ack_i & irq_o;
  assign vec_o     = res_q.vec;
  assign lvl_o     = res_q.lvl;
endmodule

module ivc_checker #(
  parameter int NUM_SRC  = 32,
  parameter int VEC_BASE = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               we_i,
  input logic [5:0]         addr_i,
  input logic               trap_i,
  input logic               ack_i,
  input logic               irq_o,
  input logic [6:0]         vec_o,
  input logic [3:0]         lvl_o,
  input logic [3:0]         cpu_lvl_o,
  input logic [NUM_SRC-1:0] flag_q,
  input logic               nest_off
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> ((flag_q & $past(src_i)) == $past(src_i))); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !(|src_i) && !we_i) |=> $stable(flag_q)); // R1
  AST_ACK_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ack_i && irq_o && !nest_off) |=> (cpu_lvl_o[2:0] == $past(lvl_o[2:0]))); // R9
  AST_ACK_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && nest_off) |=> (cpu_lvl_o[2:0] == 3'd7)); // R9
  AST_TRAP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |-> !irq_o); // R8
  AST_IPL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !(ack_i && irq_o) && !(we_i && addr_i == 6'd1)) |=> $stable(cpu_lvl_o[2:0])); // R8
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_o != 4'd0) |-> (int'(vec_o) >= VEC_BASE && int'(vec_o) < VEC_BASE + NUM_SRC)); // R5
endmodule

bind ivc_top ivc_checker #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .trap_i    (trap_i),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .lvl_o     (lvl_o),
  .cpu_lvl_o (cpu_lvl_o),
  .flag_q    (flag_w),
  .nest_off  (nest_off_w)
);

// File: tb/tb_ivc_top.sv
`timescale 1ns/1ps
module tb_ivc_top;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          we = 1'b0;
  logic [5:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          trap = 1'b0;
  logic          ack = 1'b0;
  logic          irq;
  logic [6:0]    vec;
  logic [3:0]    lvl;
  logic [3:0]    cpu_lvl;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ivc_top #(.NUM_SRC(NS), .VEC_BASE(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trap_i(trap), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .lvl_o(lvl), .cpu_lvl_o(cpu_lvl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    @(negedge clk); src = m;
    @(negedge clk); src = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1;
  endtask

  task automatic clear_all();
    wr(8, 16'hFFFF); wr(9, 16'hFFFF); wr(12, 16'h0); wr(13, 16'h0);
    for (int p = 16; p < 24; p++) wr(6'(p), 16'h0);
    wr(1, 16'h0); wr(0, 16'h0);
    tick(); tick(); #1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    #1;
    chk("reset irq", 32'(irq), 0);
    chk("reset vec", 32'(vec), 0);
    chk("reset lvl", 32'(lvl), 0);
    chk("reset cpu_lvl", 32'(cpu_lvl), 0);
    rd(8, d);  chk("reset flags", 32'(d), 0);
    rd(16, d); chk("reset prio", 32'(d), 0);
  endtask

  task automatic t_flag_r1();
    logic [15:0] d;
    clear_all();
    pulse((NS'(1) << 3) | (NS'(1) << 20));
    rd(8, d); chk("R1 flag reg 8 set", 32'(d), 32'h0008);
    rd(9, d); chk("R1 flag reg 9 set", 32'(d), 32'h0010);
    wr(9, 16'h0000);
    rd(9, d); chk("R1 zero write keeps", 32'(d), 32'h0010);
    wr(8, 16'h0008);
    rd(8, d); chk("R1 w1c clears", 32'(d), 32'h0000);
    rd(9, d); chk("R1 other reg kept", 32'(d), 32'h0010);
    wr(9, 16'h0010);
    rd(9, d); chk("R1 reg 9 cleared", 32'(d), 32'h0000);
  endtask

  task automatic t_set_wins_r2();
    logic [15:0] d;
    clear_all();
    @(negedge clk);
    src = NS'(1) << 5; we = 1'b1; addr = 6'd8; wdata = 16'h0020;
    @(negedge clk);
    src = '0; we = 1'b0;
    rd(8, d); chk("R2 set beats clear", 32'(d), 32'h0020);
    wr(8, 16'h0020);
    rd(8, d); chk("R2 later clear", 32'(d), 32'h0000);
  endtask

  task automatic t_prio_r4();
    logic [15:0] d;
    clear_all();
    wr(16, 16'hFFFF);
    rd(16, d); chk("R4 nibble bit3 reads 0", 32'(d), 32'h7777);
    wr(17, 16'h0005);
    rd(17, d); chk("R4 src4 field", 32'(d), 32'h0005);
    rd(16, d); chk("R4 neighbour untouched", 32'(d), 32'h7777);
  endtask

  task automatic t_enable_r3();
    clear_all();
    wr(16, 16'h0600);
    pulse(NS'(1) << 2);
    tick(); #1;
    chk("R3 disabled lvl", 32'(lvl), 0);
    chk("R3 disabled irq", 32'(irq), 0);
    wr(12, 16'h0004);
    tick(); #1;
    chk("R3 enabled lvl", 32'(lvl), 6);
    chk("R3 enabled vec", 32'(vec), 10);
    chk("R7 irq above cpu", 32'(irq), 1);
    wr(16, 16'h0000);
    tick(); #1;
    chk("R4 prio0 disables lvl", 32'(lvl), 0);
    chk("R4 prio0 disables irq", 32'(irq), 0);
  endtask

  task automatic t_arb_r5();
    clear_all();
    wr(16, 16'h0030); wr(20, 16'h0500);
    wr(12, 16'h0002); wr(13, 16'h0004);
    pulse((NS'(1) << 1) | (NS'(1) << 18));
    #1;
    chk("R5 not yet latched", 32'(lvl), 0);
    tick(); #1;
    chk("R5 high prio lvl", 32'(lvl), 5);
    chk("R5 high prio vec", 32'(vec), 26);
    wr(9, 16'h0004);
    tick(); #1;
    chk("R5 next winner lvl", 32'(lvl), 3);
    chk("R5 next winner vec", 32'(vec), 9);
  endtask

  task automatic t_tie_r6();
    clear_all();
    wr(17, 16'h4000); wr(23, 16'h0400);
    wr(12, 16'h0080); wr(13, 16'h4000);
    pulse((NS'(1) << 7) | (NS'(1) << 30));
    tick(); #1;
    chk("R6 tie lower index vec", 32'(vec), 15);
    chk("R6 tie lvl", 32'(lvl), 4);
    clear_all();
    wr(16, 16'h0022); wr(12, 16'h0003);
    pulse(NS'(3));
    tick(); #1;
    chk("R6 tie src0 vec", 32'(vec), 8);
    chk("R6 tie src0 lvl", 32'(lvl), 2);
  endtask

  task automatic setup_src9(input logic [15:0] pr);
    clear_all();
    wr(18, pr); wr(12, 16'h0200);
    pulse(NS'(1) << 9);
    tick(); #1;
  endtask

  task automatic t_cmp_r7();
    logic [15:0] d;
    setup_src9(16'h0030);
    wr(1, 16'h0003); #1;
    chk("R7 equal level no irq", 32'(irq), 0);
    wr(1, 16'h0002); #1;
    chk("R7 lower cpu irq", 32'(irq), 1);
    rd(1, d); chk("R8 cpu reg readback", 32'(d), 32'h0002);
  endtask

  task automatic t_cpu_r8();
    logic [15:0] d;
    setup_src9(16'h0070);
    wr(1, 16'hFFFF);
    rd(1, d); chk("R8 only low bits stored", 32'(d), 32'h0007);
    wr(1, 16'h0000); #1;
    chk("R8 prio7 irq", 32'(irq), 1);
    @(negedge clk); trap = 1'b1; #1;
    chk("R8 trap masks irq", 32'(irq), 0);
    chk("R8 trap cpu_lvl", 32'(cpu_lvl), 32'h8);
    rd(1, d); chk("R8 trap top bit read", 32'(d), 32'h0008);
    @(negedge clk); trap = 1'b0; #1;
    chk("R8 trap release irq", 32'(irq), 1);
  endtask

  task automatic t_ack_r9();
    logic [15:0] d;
    setup_src9(16'h0030);
    chk("R9 irq before ack", 32'(irq), 1);
    do_ack();
    chk("R9 ack raises cpu", 32'(cpu_lvl), 3);
    chk("R9 irq drops", 32'(irq), 0);
    wr(1, 16'h0001); #1;
    chk("R9 irq again", 32'(irq), 1);
    wr(1, 16'h0005);
    do_ack();
    chk("R9 ack ignored without irq", 32'(cpu_lvl), 5);
    wr(0, 16'h0001);
    rd(0, d); chk("R9 nest bit readback", 32'(d), 32'h0001);
    wr(1, 16'h0000); #1;
    do_ack();
    chk("R9 nest off forces 7", 32'(cpu_lvl), 7);
  endtask

  task automatic t_res_r10();
    logic [15:0] d;
    setup_src9(16'h0030);
    rd(2, d); chk("R10 result reg", 32'(d), 32'h0311);
    wr(2, 16'h0000);
    rd(2, d); chk("R10 write ignored", 32'(d), 32'h0311);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flag_r1();
    t_set_wins_r2();
    t_prio_r4();
    t_enable_r3();
    t_arb_r5();
    t_tie_r6();
    t_cmp_r7();
    t_cpu_r8();
    t_ack_r9();
    t_res_r10();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule